// File: doc/BRIEF.md
# Integer Multiply-Accumulate and Divide Unit

This unit sits beside an integer pipeline and executes 32-bit multiplies, multiply-accumulates into a 64-bit HI:LO register pair, a multiply whose low word returns straight to a general register, and 32-bit divides. Multiplies take fewer cycles when the operand values are small. The unit inspects the operand values at issue time to choose between a short and a long timing class. Divides use a bit-serial datapath with a fixed cycle count.

Operations arrive on a valid/ready issue port. The unit holds `iss_ready` low until its issue interval has elapsed, so the pipeline interlocks simply by waiting. An operation is taken at the rising edge where both `iss_valid` and `iss_ready` are high; this is the acceptance edge. Multiplies may overlap: a second multiply may be accepted before the first one finishes. Results that target a general register come out on a result strobe together with the destination tag. This strobe has no back-pressure; the consumer must take it in the cycle it is shown.

HI and LO are read and written through a valid/ready port each. While any operation that will write HI:LO is still pending, both ports hold their ready low. A read therefore sees the newest result, and a write cannot be overtaken by an older operation. Read data is combinational and is valid in any cycle where `hl_rd_valid` and `hl_rd_ready` are both high.

Top module: `intmac_unit`

## Requirements
- R1: When both operands pass the short test, a HI:LO multiply or multiply-accumulate writes HI:LO at the 3rd rising edge after its acceptance edge. The next operation can be accepted no earlier than 2 edges after the acceptance edge.
- R2: When either operand fails the short test, the same operations write HI:LO at the 4th edge after acceptance, with a minimum issue spacing of 3 edges.
- R3: The short test depends on the operand value and the signedness of the opcode, not on the opcode family. For a signed opcode, bits 31..15 of the operand must all be equal. For an unsigned opcode, bits 31..16 must be zero. Example: 0xFFFF8000 is short when signed and long when unsigned.
- R4: A multiply places the full 64-bit product in HI:LO, with the upper word in HI and the lower word in LO. The operands are treated as two's complement for signed opcodes and as unsigned otherwise.
- R5: A multiply-accumulate adds the 64-bit product to the HI:LO value present when it completes, wrapping modulo 2^64.
- R6: A direct multiply leaves HI:LO unchanged. It raises `res_valid` for exactly the one cycle that ends at the edge where it completes (edge 3 after acceptance if short, edge 4 if long). In that cycle it shows the low 32 product bits on `res_data` and its tag on `res_tag`. Its minimum issue spacing is 3 edges when short and 5 edges when long.
- R7: A divide writes the quotient to LO and the remainder to HI at the 36th edge after acceptance. The quotient truncates toward zero and the remainder takes the sign of the dividend. `iss_ready` stays low until that edge, and the next operation can be accepted at that edge. The case 0x80000000 / -1 signed gives quotient 0x80000000 and remainder 0.
- R8: While an operation that will write HI:LO is pending, `hl_rd_ready` is low. It goes high in the cycle after the last pending write edge.
- R9: A HI/LO write (`hl_wr_sel` 0 selects LO, 1 selects HI) is accepted only when `hl_wr_ready` is high. `hl_wr_ready` is low under the same pending condition as R8. An accepted write updates only the selected register.
- R10: A divide by zero completes at the same edge as any other divide, does not extend the issue block, and raises no exception.
- R11: Overlapping multiply-accumulates complete in issue order, and each one adds onto the result of the one before it.
- R12: `iss_op` encoding: 0 signed multiply, 1 unsigned multiply, 2 signed multiply-accumulate, 3 unsigned multiply-accumulate, 4 signed direct multiply, 5 unsigned direct multiply, 6 signed divide, 7 unsigned divide. Bit 0 set means unsigned.
- R13: After reset, HI and LO are zero, `iss_ready` is high and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Unit can accept an operation |
| iss_op | input | 3 | Operation code (R12) |
| iss_a | input | 32 | First operand / dividend |
| iss_b | input | 32 | Second operand / divisor |
| iss_tag | input | 5 | Destination register tag for a direct multiply |
| res_valid | output | 1 | Writeback strobe for a direct multiply |
| res_tag | output | 5 | Destination tag of the result |
| res_data | output | 32 | Low product word |
| hl_rd_valid | input | 1 | HI/LO read request |
| hl_rd_sel | input | 1 | 0 reads LO, 1 reads HI |
| hl_rd_ready | output | 1 | Read data valid; low while a HI:LO write is pending |
| hl_rd_data | output | 32 | Selected register value |
| hl_wr_valid | input | 1 | HI/LO write request |
| hl_wr_sel | input | 1 | 0 writes LO, 1 writes HI |
| hl_wr_data | input | 32 | Write value |
| hl_wr_ready | output | 1 | Write can be accepted |

## Verification
The bench targets the operand values on either side of the short test, under both signed and unsigned opcodes. A detector that got this wrong would produce the right values one cycle early or late, and a latency-exact read exposes that. It overlaps multiply-accumulates at the minimum spacing: a unit that summed with a stale HI:LO, or completed out of order, would leave a wrong final sum. Direct multiplies are checked for the exact strobe cycle and tag, for leaving HI:LO untouched, and for their longer issue spacing. Divides are checked for signed rounding, the signed overflow case, divide by zero, and an interlock that must release on exactly the 36th edge, neither sooner nor later.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_MAC_S  = 3'd2,
    OP_MAC_U  = 3'd3,
    OP_MULG_S = 3'd4,
    OP_MULG_U = 3'd5,
    OP_DIV_S  = 3'd6,
    OP_DIV_U  = 3'd7
  } mdu_op_e;

  function automatic logic op_is_div(input logic [2:0] op);
    return op[2:1] == 2'b11;
  endfunction

  function automatic logic op_is_gpr(input logic [2:0] op);
    return op[2:1] == 2'b10;
  endfunction

  function automatic logic op_is_acc(input logic [2:0] op);
    return op[2:1] == 2'b01;
  endfunction
endpackage

// File: rtl/mdu_opsize.sv
module mdu_opsize #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         uns,
  output logic         short_o
);
  localparam int H = W / 2;

  logic a_sgn_short, b_sgn_short, a_uns_short, b_uns_short;

  // signed: upper half plus the half's sign bit must be a pure sign extension
  assign a_sgn_short = (&a[W-1:H-1]) | ~(|a[W-1:H-1]);
  assign b_sgn_short = (&b[W-1:H-1]) | ~(|b[W-1:H-1]);
  // unsigned: upper half must be zero
  assign a_uns_short = ~(|a[W-1:H]);
  assign b_uns_short = ~(|b[W-1:H]);

  assign short_o = uns ? (a_uns_short & b_uns_short) : (a_sgn_short & b_sgn_short);
endmodule

// File: rtl/mdu_mult.sv
module mdu_mult #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           uns,
  output logic [2*W-1:0] prod
);
  logic signed [2*W-1:0] ea, eb;

  assign ea = {{W{~uns & a[W-1]}}, a};
  assign eb = {{W{~uns & b[W-1]}}, b};
  assign prod = ea * eb;
endmodule

// File: rtl/mdu_divider.sv
module mdu_divider #(
  parameter int W       = 32,
  parameter int DIV_CYC = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         uns,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(DIV_CYC + 1);
  localparam logic [CW-1:0] STEP_FLOOR = CW'(DIV_CYC - W);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  r_q, q_q, dvs_q;
  logic          qneg_q, rneg_q;

  logic [W-1:0]  mag_a, mag_b;
  logic [W:0]    trial, diff;
  logic          fits;

  assign mag_a = (!uns && a[W-1]) ? -a : a;
  assign mag_b = (!uns && b[W-1]) ? -b : b;

  assign trial = {r_q, q_q[W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = ~diff[W];

  assign busy = cnt_q != '0;
  assign done = cnt_q == CW'(1);
  assign quo  = qneg_q ? -q_q : q_q;
  assign rem  = rneg_q ? -r_q : r_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      r_q    <= '0;
      q_q    <= '0;
      dvs_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= CW'(DIV_CYC);
      r_q    <= '0;
      q_q    <= mag_a;
      dvs_q  <= mag_b;
      qneg_q <= ~uns & (a[W-1] ^ b[W-1]);
      rneg_q <= ~uns & a[W-1];
    end else if (busy) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q > STEP_FLOOR) begin
        r_q <= fits ? diff[W-1:0] : trial[W-1:0];
        q_q <= {q_q[W-2:0], fits};
      end
    end
  end
endmodule

// File: rtl/intmac_unit.sv
module intmac_unit #(
  parameter int W       = 32,
  parameter int TAG_W   = 5,
  parameter int LAT_S   = 3,
  parameter int LAT_L   = 4,
  parameter int REP_S   = 2,
  parameter int REP_L   = 3,
  parameter int GST_S   = 1,
  parameter int GST_L   = 2,
  parameter int DIV_CYC = 36,
  parameter int NSLOT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [2:0]       iss_op,
  input  logic [W-1:0]     iss_a,
  input  logic [W-1:0]     iss_b,
  input  logic [TAG_W-1:0] iss_tag,
  output logic             res_valid,
  output logic [TAG_W-1:0] res_tag,
  output logic [W-1:0]     res_data,
  input  logic             hl_rd_valid,
  input  logic             hl_rd_sel,
  output logic             hl_rd_ready,
  output logic [W-1:0]     hl_rd_data,
  input  logic             hl_wr_valid,
  input  logic             hl_wr_sel,
  input  logic [W-1:0]     hl_wr_data,
  output logic             hl_wr_ready
);
  import mdu_pkg::*;

  localparam int CW = $clog2(DIV_CYC + 1);
  localparam int DW = 2 * W;
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  // ---------------- issue decode ----------------
  logic          op_uns, op_div, op_gpr, op_acc, op_short, iss_fire;
  logic [DW-1:0] op_prod;
  logic [CW-1:0] lat_v, rep_v, gap_v, hold_q;

  assign op_uns = iss_op[0];
  assign op_div = op_is_div(iss_op);
  assign op_gpr = op_is_gpr(iss_op);
  assign op_acc = op_is_acc(iss_op);

  mdu_opsize #(.W(W)) u_size (
    .a(iss_a), .b(iss_b), .uns(op_uns), .short_o(op_short)
  );

  mdu_mult #(.W(W)) u_mult (
    .a(iss_a), .b(iss_b), .uns(op_uns), .prod(op_prod)
  );

  always_comb begin
    lat_v = op_short ? CW'(LAT_S) : CW'(LAT_L);
    rep_v = op_short ? CW'(REP_S) : CW'(REP_L);
    if (op_div)      gap_v = CW'(DIV_CYC);
    else if (op_gpr) gap_v = rep_v + (op_short ? CW'(GST_S) : CW'(GST_L));
    else             gap_v = rep_v;
  end

  // ---------------- in-flight multiply slots ----------------
  logic              s_vld  [NSLOT];
  logic [CW-1:0]     s_cnt  [NSLOT];
  logic [DW-1:0]     s_prod [NSLOT];
  logic              s_acc  [NSLOT];
  logic              s_gpr  [NSLOT];
  logic [TAG_W-1:0]  s_tag  [NSLOT];
  logic [NSLOT-1:0]  s_fin, s_free;

  logic [SW-1:0]     alloc_idx;
  logic              any_free;
  logic              done_any, done_gpr, done_acc;
  logic [DW-1:0]     done_prod;
  logic [TAG_W-1:0]  done_tag;
  logic              hl_pend_mul;

  always_comb begin
    alloc_idx   = '0;
    any_free    = 1'b0;
    done_any    = 1'b0;
    done_gpr    = 1'b0;
    done_acc    = 1'b0;
    done_prod   = '0;
    done_tag    = '0;
    hl_pend_mul = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      s_fin[i]  = s_vld[i] && (s_cnt[i] == CW'(1));
      s_free[i] = !s_vld[i] || s_fin[i];
      if (s_vld[i] && !s_gpr[i]) hl_pend_mul = 1'b1;
      if (s_fin[i]) begin
        done_any  = 1'b1;
        done_gpr  = s_gpr[i];
        done_acc  = s_acc[i];
        done_prod = s_prod[i];
        done_tag  = s_tag[i];
      end
    end
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (s_free[i]) begin
        alloc_idx = SW'(i);
        any_free  = 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s_vld[g]  <= 1'b0;
          s_cnt[g]  <= '0;
          s_prod[g] <= '0;
          s_acc[g]  <= 1'b0;
          s_gpr[g]  <= 1'b0;
          s_tag[g]  <= '0;
        end else if (iss_fire && !op_div && alloc_idx == SW'(g)) begin
          s_vld[g]  <= 1'b1;
          s_cnt[g]  <= lat_v;
          s_prod[g] <= op_prod;
          s_acc[g]  <= op_acc;
          s_gpr[g]  <= op_gpr;
          s_tag[g]  <= iss_tag;
        end else if (s_fin[g]) begin
          s_vld[g] <= 1'b0;
          s_cnt[g] <= '0;
        end else if (s_vld[g]) begin
          s_cnt[g] <= s_cnt[g] - CW'(1);
        end
      end
    end
  endgenerate

  // ---------------- divider ----------------
  logic          div_busy, div_done;
  logic [W-1:0]  div_quo, div_rem;

  mdu_divider #(.W(W), .DIV_CYC(DIV_CYC)) u_div (
    .clk(clk), .rst_n(rst_n),
    .start(iss_fire && op_div),
    .a(iss_a), .b(iss_b), .uns(op_uns),
    .busy(div_busy), .done(div_done),
    .quo(div_quo), .rem(div_rem)
  );

  // ---------------- issue interlock ----------------
  assign iss_ready = (hold_q == '0) && any_free;
  assign iss_fire  = iss_valid && iss_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)              hold_q <= '0;
    else if (iss_fire)       hold_q <= gap_v - CW'(1);
    else if (hold_q != '0)   hold_q <= hold_q - CW'(1);
  end

  // ---------------- HI:LO state ----------------
  logic [DW-1:0] hilo_q;
  logic          hl_pend, hl_wr_fire;

  assign hl_pend     = hl_pend_mul || div_busy;
  assign hl_rd_ready = !hl_pend;
  assign hl_wr_ready = !hl_pend;
  assign hl_wr_fire  = hl_wr_valid && hl_wr_ready;
  assign hl_rd_data  = hl_rd_sel ? hilo_q[DW-1:W] : hilo_q[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hilo_q <= '0;
    end else if (div_done) begin
      hilo_q <= {div_rem, div_quo};
    end else if (done_any && !done_gpr) begin
      hilo_q <= (done_acc ? hilo_q : '0) + done_prod;
    end else if (hl_wr_fire) begin
      if (hl_wr_sel) hilo_q[DW-1:W] <= hl_wr_data;
      else           hilo_q[W-1:0]  <= hl_wr_data;
    end
  end

  // ---------------- general-register result ----------------
  assign res_valid = done_any && done_gpr;
  assign res_data  = done_prod[W-1:0];
  assign res_tag   = done_tag;
endmodule

// File: rtl/intmac_chk.sv
module intmac_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iss_valid,
  input logic       iss_ready,
  input logic [2:0] iss_op,
  input logic       res_valid,
  input logic       hl_rd_ready
);
  // R7
  div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_op[2:1] == 2'b11) |=> !iss_ready);

  // R1
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !iss_ready);

  // R8
  hl_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && (!iss_op[2] || iss_op[1])) |=> !hl_rd_ready);

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind intmac_unit intmac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_op(iss_op), .res_valid(res_valid), .hl_rd_ready(hl_rd_ready)
);

// File: tb/sim_intmac_unit.sv
module sim_intmac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [2:0]  iss_op = '0;
  logic [31:0] iss_a = '0, iss_b = '0;
  logic [4:0]  iss_tag = '0;
  logic        res_valid;
  logic [4:0]  res_tag;
  logic [31:0] res_data;
  logic        hl_rd_valid = 1'b0, hl_rd_sel = 1'b0, hl_rd_ready;
  logic [31:0] hl_rd_data;
  logic        hl_wr_valid = 1'b0, hl_wr_sel = 1'b0, hl_wr_ready;
  logic [31:0] hl_wr_data = '0;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  intmac_unit u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b), .iss_tag(iss_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .hl_rd_valid(hl_rd_valid), .hl_rd_sel(hl_rd_sel), .hl_rd_ready(hl_rd_ready),
    .hl_rd_data(hl_rd_data), .hl_wr_valid(hl_wr_valid), .hl_wr_sel(hl_wr_sel),
    .hl_wr_data(hl_wr_data), .hl_wr_ready(hl_wr_ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] tag, output int acc);
    iss_valid = 1'b1; iss_op = op; iss_a = a; iss_b = b; iss_tag = tag;
    #1;
    while (!iss_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic read_hl(input logic sel, output logic [31:0] d, output int e);
    hl_rd_valid = 1'b1; hl_rd_sel = sel;
    #1;
    while (!hl_rd_ready) @(negedge clk);
    #1;
    d = hl_rd_data;
    e = cyc;
    @(negedge clk);
    hl_rd_valid = 1'b0;
  endtask

  task automatic write_hl(input logic sel, input logic [31:0] d, output int e);
    hl_wr_valid = 1'b1; hl_wr_sel = sel; hl_wr_data = d;
    #1;
    while (!hl_wr_ready) @(negedge clk);
    e = cyc + 1;
    @(negedge clk);
    hl_wr_valid = 1'b0;
  endtask

  task automatic wait_res(output logic [4:0] t, output logic [31:0] d, output int e);
    while (!res_valid) @(negedge clk);
    t = res_tag; d = res_data; e = cyc + 1;
    @(negedge clk);
  endtask

  // one multiply, checks latency and 64-bit value
  task automatic mul_case(input string req, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input int lat, input logic [63:0] exp);
    int c0, e;
    logic [31:0] lo, hi;
    issue(op, a, b, 5'd0, c0);
    read_hl(1'b0, lo, e);
    chk({req, " latency"}, 64'(e - c0), 64'(lat));
    read_hl(1'b1, hi, e);
    chk({req, " value"}, {hi, lo}, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    int e;
    chk("R13 iss_ready", 64'(iss_ready), 64'd1);
    chk("R13 res_valid", 64'(res_valid), 64'd0);
    read_hl(1'b0, d, e);
    chk("R13 LO", 64'(d), 64'd0);
    read_hl(1'b1, d, e);
    chk("R13 HI", 64'(d), 64'd0);
  endtask

  task automatic t_basic_mul;
    // R12 opcode 0 signed, 1 unsigned
    mul_case("R1 R4 signed short", 3'd0, 32'hFFFFFFFD, 32'd7, 3, 64'hFFFFFFFF_FFFFFFEB);
    mul_case("R2 R4 unsigned long", 3'd1, 32'hFFFFFFFF, 32'd2, 4, 64'h1_FFFFFFFE);
  endtask

  task automatic t_size_edges;
    mul_case("R3 u 0xFFFF short", 3'd1, 32'h0000FFFF, 32'h0000FFFF, 3, 64'h0_FFFE0001);
    mul_case("R3 s 0xFFFF long", 3'd0, 32'h0000FFFF, 32'd1, 4, 64'h0_0000FFFF);
    mul_case("R3 s 0xFFFF8000 short", 3'd0, 32'hFFFF8000, 32'd2, 3, 64'hFFFFFFFF_FFFF0000);
    mul_case("R3 u 0xFFFF8000 long", 3'd1, 32'hFFFF8000, 32'd2, 4, 64'h1_FFFF0000);
  endtask

  task automatic t_interval;
    int c1, c2, e;
    logic [31:0] d;
    issue(3'd0, 32'd3, 32'd3, 5'd0, c1);
    issue(3'd0, 32'd4, 32'd4, 5'd0, c2);
    chk("R1 short repeat", 64'(c2 - c1), 64'd2);
    read_hl(1'b0, d, e);
    chk("R1 overlapped latency", 64'(e - c2), 64'd3);
    chk("R1 overlapped value", 64'(d), 64'd16);
    issue(3'd1, 32'h00010000, 32'd1, 5'd0, c1);
    issue(3'd1, 32'd1, 32'd1, 5'd0, c2);
    chk("R2 long repeat", 64'(c2 - c1), 64'd3);
    read_hl(1'b0, d, e);
    chk("R2 value", 64'(d), 64'd1);
  endtask

  task automatic t_mac;
    int c1, c2, e;
    logic [31:0] lo, hi;
    write_hl(1'b1, 32'h0, e);
    write_hl(1'b0, 32'hFFFFFFFF, e);
    read_hl(1'b0, lo, e);
    chk("R9 LO write", 64'(lo), 64'hFFFFFFFF);
    issue(3'd3, 32'd1, 32'd1, 5'd0, c1);          // R12 unsigned MAC
    read_hl(1'b0, lo, e);
    chk("R8 read stalls to MAC write", 64'(e - c1), 64'd3);
    read_hl(1'b1, hi, e);
    chk("R5 carry into HI", {hi, lo}, 64'h1_00000000);
    issue(3'd2, 32'hFFFFFFFE, 32'd3, 5'd0, c1);   // R12 signed MAC
    issue(3'd2, 32'd5, 32'd5, 5'd0, c2);
    chk("R11 MAC spacing", 64'(c2 - c1), 64'd2);
    read_hl(1'b0, lo, e);
    chk("R11 last MAC latency", 64'(e - c2), 64'd3);
    read_hl(1'b1, hi, e);
    chk("R11 R5 accumulated sum", {hi, lo}, 64'h1_00000013);
  endtask

  task automatic t_direct;
    int c1, c2, e;
    logic [4:0] t;
    logic [31:0] d;
    write_hl(1'b1, 32'hAAAA5555, e);
    write_hl(1'b0, 32'h12345678, e);
    issue(3'd4, 32'hFFFFFFFC, 32'd5, 5'd9, c1);   // R12 signed direct
    wait_res(t, d, e);
    chk("R6 short strobe edge", 64'(e - c1), 64'd3);
    chk("R6 data", 64'(d), 64'hFFFFFFEC);
    chk("R6 tag", 64'(t), 64'd9);
    issue(3'd5, 32'h00010000, 32'd3, 5'd4, c1);   // R12 unsigned direct
    wait_res(t, d, e);
    chk("R6 long strobe edge", 64'(e - c1), 64'd4);
    chk("R6 long data", 64'(d), 64'h00030000);
    chk("R6 long tag", 64'(t), 64'd4);
    issue(3'd4, 32'd2, 32'd2, 5'd1, c1);
    issue(3'd4, 32'd3, 32'd3, 5'd2, c2);
    chk("R6 short direct spacing", 64'(c2 - c1), 64'd3);
    wait_res(t, d, e);
    issue(3'd5, 32'h00020000, 32'd1, 5'd3, c1);
    issue(3'd4, 32'd2, 32'd2, 5'd1, c2);
    chk("R6 long direct spacing", 64'(c2 - c1), 64'd5);
    wait_res(t, d, e);
    chk("R6 following result", {32'(t), d}, {32'd1, 32'd4});
    read_hl(1'b1, d, e);
    chk("R6 HI untouched", 64'(d), 64'hAAAA5555);
    read_hl(1'b0, d, e);
    chk("R6 LO untouched", 64'(d), 64'h12345678);
  endtask

  task automatic div_case(input string req, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] q, input logic [31:0] r);
    int c0, e;
    logic [31:0] lo, hi;
    issue(op, a, b, 5'd0, c0);
    read_hl(1'b0, lo, e);
    chk({req, " edge"}, 64'(e - c0), 64'd36);
    read_hl(1'b1, hi, e);
    chk({req, " rem:quo"}, {hi, lo}, {r, q});
  endtask

  task automatic t_divide;
    int c1, c2, e;
    logic [31:0] d;
    div_case("R7 signed -7/2", 3'd6, 32'hFFFFFFF9, 32'd2, 32'hFFFFFFFD, 32'hFFFFFFFF);
    div_case("R7 signed 7/-2", 3'd6, 32'd7, 32'hFFFFFFFE, 32'hFFFFFFFD, 32'd1);
    div_case("R7 unsigned 100/7", 3'd7, 32'd100, 32'd7, 32'd14, 32'd2);
    div_case("R7 signed overflow", 3'd6, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'd0);
    issue(3'd7, 32'd100, 32'd7, 5'd0, c1);
    issue(3'd1, 32'd2, 32'd3, 5'd0, c2);
    chk("R7 issue blocked until done", 64'(c2 - c1), 64'd36);
    read_hl(1'b0, d, e);
    chk("R7 follow-on multiply", 64'(d), 64'd6);
    issue(3'd7, 32'd5, 32'd0, 5'd0, c1);
    read_hl(1'b0, d, e);
    chk("R10 divide by zero edge", 64'(e - c1), 64'd36);
    issue(3'd6, 32'd5, 32'd0, 5'd0, c1);
    issue(3'd0, 32'd1, 32'd1, 5'd0, c2);
    chk("R10 divide by zero block", 64'(c2 - c1), 64'd36);
    read_hl(1'b0, d, e);
  endtask

  task automatic t_write_block;
    int c0, e;
    logic [31:0] d;
    issue(3'd1, 32'h00010000, 32'd2, 5'd0, c0);
    chk("R9 write blocked while pending", 64'(hl_wr_ready), 64'd0);
    write_hl(1'b1, 32'h77, e);
    chk("R9 write accept edge", 64'(e - c0), 64'd5);
    read_hl(1'b1, d, e);
    chk("R9 HI written", 64'(d), 64'h77);
    read_hl(1'b0, d, e);
    chk("R9 LO kept product", 64'(d), 64'h00020000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_mul();
    t_size_edges();
    t_interval();
    t_mac();
    t_direct();
    t_divide();
    t_write_block();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule